// File: doc/BRIEF.md
# Doorbell Mailbox Sideband Bridge

The bridge gives a host a three-register window through which it can reach registers inside a remote power-management unit over a simple sideband link. First the host loads a target address into the address register. For a write it also loads the write data into the data register. It then stores a command word into the doorbell register. The command word selects the device/function, the opcode, the destination port, the byte enables and a BAR index.

Bit 0 of the doorbell register reads as a busy flag. Storing a command raises the flag. The bridge then issues one sideband request and waits for the one-cycle response pulse. On a read it keeps the returned word in the data register, and then it drops the flag. The host polls the flag, collects read data from the data register, and clears that register afterwards. A small target-side register model with byte-lane writes is part of the project, so that the whole path can be exercised end to end.

Top module: `sb_mailbox_bridge`

## Requirements
- R1: After reset the doorbell, data and address registers all read zero, busy (doorbell bit 0) is 0, and no sideband request is driven.
- R2: The address register keeps only its 8 low bits and reads back zero-extended to 32 bits.
- R3: The host map is word-aligned: doorbell at offset 0x0, data at 0x4, address at 0x8. A doorbell store made while busy is 0 keeps bits 31:1 and sets busy from the next cycle. Bits 31:24 are device/function, 23:16 opcode, 15:8 port, 7:4 byte enables and 3:1 BAR.
- R4: When opcode 6 (read) or 7 (write) is accepted, exactly one request cycle is driven, in the cycle after the store. The request carries the address, opcode, port, byte enables, device/function, BAR and the data register as write data.
- R5: Busy clears in the cycle after the response pulse. With the one-cycle target model, busy is therefore seen high for exactly two cycles.
- R6: A read stores the response word in the data register. A write leaves the data register unchanged.
- R7: Any other opcode issues no request and clears busy after one cycle. The target contents do not change.
- R8: A doorbell store made while busy is 1 is ignored. This includes a store that lands in the completion cycle. It causes no further request and leaves the stored command unchanged.
- R9: While busy is 1, stores to the address and data registers are ignored.
- R10: The target model answers only requests to port 0x4. On a write it updates only the byte lanes whose enable bit is 1, and a read returns the stored word. A request to any other port changes nothing and returns zero.
- R11: Once a transaction has completed, the host can write the data register back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host byte offset (0x0 doorbell, 0x4 data, 0x8 address) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected offset |
| sb_req | output | 1 | Sideband request valid, one cycle |
| sb_devfn | output | 8 | Request device/function |
| sb_opcode | output | 8 | Request opcode |
| sb_port | output | 8 | Request destination port |
| sb_be | output | 4 | Request byte enables |
| sb_bar | output | 3 | Request BAR index |
| sb_addr | output | 8 | Request register address |
| sb_wdata | output | 32 | Request write data |
| sb_rsp | input | 1 | Response pulse from target |
| sb_rdata | input | 32 | Response read data, valid with sb_rsp |

## Verification
Two events can fall in the same clock edge: the response arrives, which would accept read data and drop busy, and the host stores a new doorbell or a new data word. The bench provokes this by storing a second doorbell immediately after a read, timed so that it lands on the completion edge. It then checks three things: the request counter rose by only one, the doorbell fields are unchanged, and the data register holds the target word rather than anything the host wrote.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef struct packed {
      logic [7:0] devfn;
      logic [7:0] opcode;
      logic [7:0] port;
      logic [3:0] be;
      logic [2:0] bar;
      logic       busy;
   } mbx_cmd_t;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ISSUE = 2'd1,
      SEQ_WAIT  = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_DATA = 2'd1,
      SEL_ADDR = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_t;

   localparam logic [7:0] OP_REG_RD = 8'd6;
   localparam logic [7:0] OP_REG_WR = 8'd7;

endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int OFFS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [OFFS_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              busy,
   input  logic              rsp_load,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              cmd_accept,
   output mbx_cmd_t          cmd_q,
   output logic [DATA_W-1:0] data_q,
   output logic [ADDR_W-1:0] addr_q
);

   localparam int SEL_LSB = 2;

   generate
      if (DATA_W != $bits(mbx_cmd_t)) begin : g_bad_width
         $error("mbx_host_regs: DATA_W must equal the command word width");
      end
      if (OFFS_W != SEL_LSB + 2) begin : g_bad_offs
         $error("mbx_host_regs: OFFS_W must cover exactly four word offsets");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("mbx_host_regs: ADDR_W exceeds DATA_W");
      end
   endgenerate

   reg_sel_t sel;
   logic     aligned;
   logic     wr_data, wr_addr;

   assign aligned    = (host_addr[SEL_LSB-1:0] == '0);
   assign sel        = aligned ? reg_sel_t'(host_addr[SEL_LSB+1:SEL_LSB]) : SEL_NONE;
   assign cmd_accept = host_we && (sel == SEL_CMD) && !busy;
   assign wr_data    = host_we && (sel == SEL_DATA) && !busy;
   assign wr_addr    = host_we && (sel == SEL_ADDR) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
         addr_q <= '0;
      end else begin
         if (cmd_accept) begin
            cmd_q      <= mbx_cmd_t'(host_wdata);
            cmd_q.busy <= 1'b0;
         end
         if (rsp_load) begin
            data_q <= rsp_data;
         end else if (wr_data) begin
            data_q <= host_wdata;
         end
         if (wr_addr) begin
            addr_q <= host_wdata[ADDR_W-1:0];
         end
      end
   end

   always_comb begin
      case (sel)
         SEL_CMD:  host_rdata = DATA_W'(cmd_q) | DATA_W'(busy);
         SEL_DATA: host_rdata = data_q;
         SEL_ADDR: host_rdata = DATA_W'(addr_q);
         default:  host_rdata = '0;
      endcase
   end

   // R8
   db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && sel == SEL_CMD) |=> $stable(cmd_q));

   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && sel == SEL_ADDR) |=> $stable(addr_q));

   // R9
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rsp_load && host_we && sel == SEL_DATA) |=> $stable(data_q));

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
   import mbx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_accept,
   input  logic [7:0] opcode,
   input  logic       sb_rsp,
   output logic       sb_req,
   output logic       busy,
   output logic       rsp_load
);

   seq_state_t state_q, state_d;
   logic       op_ok;

   assign op_ok = (opcode == OP_REG_RD) || (opcode == OP_REG_WR);

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_IDLE:  if (cmd_accept) state_d = SEQ_ISSUE;
         SEQ_ISSUE: state_d = op_ok ? SEQ_WAIT : SEQ_IDLE;
         SEQ_WAIT:  if (sb_rsp) state_d = SEQ_IDLE;
         default:   state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_IDLE;
      else        state_q <= state_d;
   end

   assign busy     = (state_q != SEQ_IDLE);
   assign sb_req   = (state_q == SEQ_ISSUE) && op_ok;
   assign rsp_load = (state_q == SEQ_WAIT) && sb_rsp && (opcode == OP_REG_RD);

   // R4
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req |=> !sb_req);

   // R5
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_WAIT && sb_rsp) |=> !busy);

   // R7
   badop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_accept && !busy) |=> (busy && sb_req == op_ok));

endmodule

// File: rtl/mbx_target_model.sv
module mbx_target_model #(
   parameter int          DATA_W  = 32,
   parameter int          ADDR_W  = 8,
   parameter int          DEPTH   = 16,
   parameter logic [7:0]  PORT_ID = 8'h04,
   parameter logic [7:0]  RD_OP   = 8'd6,
   parameter logic [7:0]  WR_OP   = 8'd7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [7:0]          port,
   input  logic [7:0]          opcode,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W/8-1:0] be,
   input  logic [DATA_W-1:0]   wdata,
   output logic                rsp,
   output logic [DATA_W-1:0]   rdata
);

   localparam int BE_W  = DATA_W / 8;
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_w
         $error("mbx_target_model: DATA_W must be whole bytes");
      end
      if ((1 << IDX_W) != DEPTH || IDX_W >= ADDR_W) begin : g_bad_depth
         $error("mbx_target_model: DEPTH must be a power of two below the address range");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic              in_range, hit, do_wr, do_rd;
   logic [DATA_W-1:0] word;

   assign idx      = addr[IDX_W-1:0];
   assign in_range = (addr[ADDR_W-1:IDX_W] == '0);
   assign hit      = req && (port == PORT_ID) && in_range;
   assign do_wr    = hit && (opcode == WR_OP);
   assign do_rd    = hit && (opcode == RD_OP);

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      logic [7:0] lane_mem [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
         end else if (do_wr && be[b]) begin
            lane_mem[idx] <= wdata[b*8 +: 8];
         end
      end
      assign word[b*8 +: 8] = lane_mem[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp   <= 1'b0;
         rdata <= '0;
      end else begin
         rsp   <= req;
         rdata <= do_rd ? word : '0;
      end
   end

   // R10
   foreign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && port != PORT_ID) |=> (rsp && rdata == '0));

endmodule

// File: rtl/sb_mailbox_bridge.sv
module sb_mailbox_bridge
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int OFFS_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_we,
   input  logic [OFFS_W-1:0]   host_addr,
   input  logic [DATA_W-1:0]   host_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                sb_req,
   output logic [7:0]          sb_devfn,
   output logic [7:0]          sb_opcode,
   output logic [7:0]          sb_port,
   output logic [3:0]          sb_be,
   output logic [2:0]          sb_bar,
   output logic [ADDR_W-1:0]   sb_addr,
   output logic [DATA_W-1:0]   sb_wdata,
   input  logic                sb_rsp,
   input  logic [DATA_W-1:0]   sb_rdata
);

   mbx_cmd_t          cmd_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr_q;
   logic              cmd_accept, busy, rsp_load;

   mbx_host_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .OFFS_W (OFFS_W)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .busy       (busy),
      .rsp_load   (rsp_load),
      .rsp_data   (sb_rdata),
      .cmd_accept (cmd_accept),
      .cmd_q      (cmd_q),
      .data_q     (data_q),
      .addr_q     (addr_q)
   );

   mbx_seq seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_accept (cmd_accept),
      .opcode     (cmd_q.opcode),
      .sb_rsp     (sb_rsp),
      .sb_req     (sb_req),
      .busy       (busy),
      .rsp_load   (rsp_load)
   );

   assign sb_devfn  = cmd_q.devfn;
   assign sb_opcode = cmd_q.opcode;
   assign sb_port   = cmd_q.port;
   assign sb_be     = cmd_q.be;
   assign sb_bar    = cmd_q.bar;
   assign sb_addr   = addr_q;
   assign sb_wdata  = data_q;

   // R4
   req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req |-> $stable(sb_addr) && $stable(sb_wdata));

endmodule

// File: tb/sb_mailbox_bridge_tb.sv
`timescale 1ns/100ps
module sb_mailbox_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        sb_req, sb_rsp;
   logic [7:0]  sb_devfn, sb_opcode, sb_port, sb_addr;
   logic [3:0]  sb_be;
   logic [2:0]  sb_bar;
   logic [31:0] sb_wdata, sb_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int req_cnt = 0;
   logic [7:0]  cap_devfn, cap_op, cap_port, cap_addr;
   logic [3:0]  cap_be;
   logic [31:0] cap_wdata;

   always #2 clk = ~clk;

   sb_mailbox_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .sb_req(sb_req),
      .sb_devfn(sb_devfn), .sb_opcode(sb_opcode), .sb_port(sb_port),
      .sb_be(sb_be), .sb_bar(sb_bar), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
      .sb_rsp(sb_rsp), .sb_rdata(sb_rdata)
   );

   mbx_target_model tgt_i (
      .clk(clk), .rst_n(rst_n), .req(sb_req), .port(sb_port),
      .opcode(sb_opcode), .addr(sb_addr), .be(sb_be), .wdata(sb_wdata),
      .rsp(sb_rsp), .rdata(sb_rdata)
   );

   always @(posedge clk) begin
      if (rst_n && sb_req) begin
         req_cnt   <= req_cnt + 1;
         cap_devfn <= sb_devfn;
         cap_op    <= sb_opcode;
         cap_port  <= sb_port;
         cap_be    <= sb_be;
         cap_addr  <= sb_addr;
         cap_wdata <= sb_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int n = 0; n < 50; n++) begin
         rd(4'h0, v);
         if (!v[0]) break;
         @(negedge clk);
      end
   endtask

   task automatic busy_len(output int n);
      logic [31:0] v;
      n = 0;
      for (int k = 0; k < 20; k++) begin
         rd(4'h0, v);
         if (!v[0]) break;
         n++;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] mk(input logic [7:0] op, input logic [7:0] port,
                                      input logic [3:0] be);
      return {8'h10, op, port, be, 3'b000, 1'b0};
   endfunction

   function automatic logic [31:0] pat(input int i);
      return 32'h1357_9BDF * (i + 1) ^ 32'h00A5_0000;
   endfunction

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m = '0;
      for (int k = 0; k < 4; k++) if (be[k]) m |= 32'hFF << (8 * k);
      return m;
   endfunction

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_up();
   end

   initial begin
      logic [31:0] v, c;
      int n, c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, v); chk(v == 0, "R1", "doorbell", v, 0);
      rd(4'h4, v); chk(v == 0, "R1", "data", v, 0);
      rd(4'h8, v); chk(v == 0, "R1", "address", v, 0);
      chk(sb_req == 1'b0, "R1", "sb_req", 32'(sb_req), 0);

      // R2 zero extension
      wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); chk(v == 32'hFF, "R2", "addr ext", v, 32'hFF);
      wr(4'h8, 32'h0000_0123); rd(4'h8, v); chk(v == 32'h23, "R2", "addr trunc", v, 32'h23);

      // R3 R4 R5 write transaction
      wr(4'h8, 32'h3); wr(4'h4, 32'hCAFE_0001);
      c = mk(8'd7, 8'h04, 4'hF); c0 = req_cnt;
      wr(4'h0, c);
      rd(4'h0, v); chk(v == (c | 1), "R3", "doorbell+busy", v, c | 1);
      busy_len(n); chk(n == 2, "R5", "busy cycles", n, 2);
      chk(req_cnt == c0 + 1, "R4", "one request", req_cnt, c0 + 1);
      chk(cap_op == 8'd7 && cap_port == 8'h04 && cap_be == 4'hF && cap_devfn == 8'h10,
          "R4", "req fields", {cap_devfn, cap_op, cap_port, 4'h0, cap_be},
          {8'h10, 8'd7, 8'h04, 8'h0F});
      chk(cap_addr == 8'h3 && cap_wdata == 32'hCAFE_0001, "R4", "req addr/wdata",
          cap_wdata ^ 32'(cap_addr), 32'hCAFE_0001 ^ 32'h3);
      rd(4'h4, v); chk(v == 32'hCAFE_0001, "R6", "write keeps data", v, 32'hCAFE_0001);

      // R6 R11 read back
      wr(4'h4, 32'h0); wr(4'h0, mk(8'd6, 8'h04, 4'hF)); wait_idle();
      rd(4'h4, v); chk(v == 32'hCAFE_0001, "R6", "read data", v, 32'hCAFE_0001);
      wr(4'h4, 32'h0); rd(4'h4, v); chk(v == 0, "R11", "data clear", v, 0);

      // R10 R6 sweep over the target model
      for (int i = 0; i < 16; i++) begin
         wr(4'h8, 32'(i)); wr(4'h4, pat(i)); wr(4'h0, mk(8'd7, 8'h04, 4'hF)); wait_idle();
      end
      for (int i = 0; i < 16; i++) begin
         wr(4'h8, 32'(i)); wr(4'h4, 32'h0); wr(4'h0, mk(8'd6, 8'h04, 4'hF)); wait_idle();
         rd(4'h4, v); chk(v == pat(i), "R10", "sweep readback", v, pat(i));
      end

      // R7 unknown opcode
      wr(4'h8, 32'h3); wr(4'h4, 32'h0BAD_0BAD); c0 = req_cnt;
      wr(4'h0, mk(8'h09, 8'h04, 4'hF));
      busy_len(n); chk(n == 1, "R7", "busy cycles", n, 1);
      chk(req_cnt == c0, "R7", "no request", req_cnt, c0);
      wr(4'h4, 32'h0); wr(4'h0, mk(8'd6, 8'h04, 4'hF)); wait_idle();
      rd(4'h4, v); chk(v == pat(3), "R7", "target untouched", v, pat(3));

      // R8 doorbell landing on the completion edge
      wr(4'h8, 32'h2); wr(4'h4, 32'h0); c0 = req_cnt;
      c = mk(8'd6, 8'h04, 4'hF);
      wr(4'h0, c);
      wr(4'h0, mk(8'd7, 8'h04, 4'h3));
      rd(4'h0, v); chk(v == c, "R8", "busy clear, fields kept", v, c);
      repeat (3) @(negedge clk);
      chk(req_cnt == c0 + 1, "R8", "no extra request", req_cnt, c0 + 1);
      rd(4'h4, v); chk(v == pat(2), "R8", "read data kept", v, pat(2));

      // R9 address and data stores during busy
      wr(4'h8, 32'h1); wr(4'h4, 32'h0);
      wr(4'h0, mk(8'd6, 8'h04, 4'hF));
      wr(4'h8, 32'h77); wait_idle();
      rd(4'h8, v); chk(v == 32'h1, "R9", "addr held", v, 32'h1);
      wr(4'h4, 32'hDEAD_0001); wr(4'h0, mk(8'd7, 8'h04, 4'hF));
      wr(4'h4, 32'h55); wait_idle();
      rd(4'h4, v); chk(v == 32'hDEAD_0001, "R9", "data held", v, 32'hDEAD_0001);

      // R10 byte enable sweep
      for (int b = 0; b < 16; b++) begin
         wr(4'h8, 32'h5); wr(4'h4, 32'hFFFF_FFFF);
         wr(4'h0, mk(8'd7, 8'h04, 4'hF)); wait_idle();
         wr(4'h4, 32'h0); wr(4'h0, mk(8'd7, 8'h04, 4'(b))); wait_idle();
         wr(4'h0, mk(8'd6, 8'h04, 4'hF)); wait_idle();
         rd(4'h4, v);
         chk(v == ~lane_mask(4'(b)), "R10", $sformatf("be=%0h", b), v, ~lane_mask(4'(b)));
      end

      // R10 foreign port
      wr(4'h8, 32'h6); wr(4'h4, 32'h1111_2222);
      wr(4'h0, mk(8'd7, 8'h05, 4'hF)); wait_idle();
      wr(4'h4, 32'h0); wr(4'h0, mk(8'd6, 8'h04, 4'hF)); wait_idle();
      rd(4'h4, v); chk(v == pat(6), "R10", "foreign write dropped", v, pat(6));
      wr(4'h4, 32'hAAAA); wr(4'h0, mk(8'd6, 8'h05, 4'hF)); wait_idle();
      rd(4'h4, v); chk(v == 0, "R10", "foreign read zero", v, 0);

      finish_up();
   end

endmodule